// File: doc/BRIEF.md
# Matrix Keypad Scanner with Recheck Debounce

This block scans a 4x4 matrix of key switches. It pulls one row line low at a time and reads the four column lines, which idle high. When the column under test reads low, the scanner freezes on that key position. It waits a programmable debounce interval and then reads the same position again. If the key is still closed, the block emits the key's hexadecimal character in ASCII on `keyCode` and raises `keyValid` for one clock.

After reporting, the scanner stays on that row until every column has read high for a full debounce interval. Only then does it resume scanning. One press therefore yields exactly one code, however long the key is held and however much it bounces. Column inputs pass through a reset-to-high synchronizer. After each row change the scanner waits for that pipeline to refill before it tests any column.

Top module: `kpad_scanner`

## Requirements
- R1: While reset is asserted, and on leaving reset, `rowDrive` is 4'b1110 (row 0 selected), `keyValid` is 0 and `keyCode` is 8'h00.
- R2: At every cycle exactly one bit of `rowDrive` is 0. Bit r low selects row r.
- R3: With no key pressed, rows are visited cyclically in the order 1110, 1101, 1011, 0111. Each change of `rowDrive` rotates the low bit one position toward the MSB, and row 3 is followed by row 0.
- R4: The key at row r and column c sits where row bit r driven low pulls column bit c low. Its index is k = 4r + c. The reported code is 0x30+k for k < 10 and 0x41+(k-10) for k >= 10, that is ASCII '0'-'9' and 'A'-'F'.
- R5: For a clean press from the idle scan, `keyValid` rises no fewer than DEBOUNCE_CYCLES clocks after the press. It rises no more than DEBOUNCE_CYCLES + one full scan period (rows x (sync stages + columns)) + 8 clocks after the press.
- R6: A key that is seen low but released before the recheck produces no `keyValid`, and `keyCode` keeps its previous value.
- R7: `keyValid` is high for exactly one clock per report. `keyCode` changes only in a cycle where `keyValid` is high.
- R8: A held key, including one that bounced before settling, yields exactly one report.
- R9: After a report, a new report needs all columns to read high for at least DEBOUNCE_CYCLES consecutive clocks. A shorter release followed by a re-press gives no code. A longer one lets the next press report again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| colIn | input | 4 | Column sense lines, idle high, low when a key in the driven row is closed |
| rowDrive | output | 4 | Row select lines, exactly one driven low |
| keyCode | output | 8 | ASCII hex character of the last accepted key |
| keyValid | output | 1 | One-cycle strobe marking a new `keyCode` |

## Verification
The bench presses all sixteen keys in turn. It computes each ASCII code from the row and column, so a wrong row-major index or an off-by-seven jump at 'A' shows up as a code mismatch. It bounds report latency on both sides: a recheck that skips the wait reports too early, and a scanner that loses its place reports too late or never. Short pulses released before the recheck catch a design that reports on first sight. A bounce burst, a long hold and a short release followed by a re-press catch a design that re-arms on the first high column and so reports the same press twice. Row order is watched during idle scanning, so a reversed or skipped row sequence is also caught.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

  typedef enum logic [1:0] {
    ST_SCAN    = 2'd0,
    ST_WAIT    = 2'd1,
    ST_CHECK   = 2'd2,
    ST_RELEASE = 2'd3
  } scanState_t;

  // control -> datapath
  typedef struct packed {
    logic settle;     // count down the post-row-change settle window
    logic advance;    // step to the next key position
    logic timerClr;   // zero the debounce timer
    logic timerRun;   // increment the debounce timer
    logic latchCode;  // capture the current position as a report
  } kpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic settled;    // synchronized columns reflect the driven row
    logic keyLow;     // column under test reads low
    logic allHigh;    // every column reads high
    logic timerDone;  // debounce interval elapsed
  } kpStatus_t;

  function automatic logic [7:0] hexAscii(input logic [3:0] idx);
    if (idx < 4'd10) return 8'h30 + {4'b0000, idx};
    else             return 8'h37 + {4'b0000, idx};
  endfunction

endpackage

// File: rtl/kpad_colsync.sv
module kpad_colsync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  // STAGES must be at least 2
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], dIn};
  end

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/kpad_datapath.sv
module kpad_datapath
  import kpad_pkg::*;
#(
  parameter int NUM_ROWS        = 4,
  parameter int NUM_COLS        = 4,
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 1_250_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_COLS-1:0] colIn,
  input  kpStrobe_t           strb,
  output kpStatus_t           stat,
  output logic [NUM_ROWS-1:0] rowDrive,
  output logic [7:0]          keyCode,
  output logic                keyValid
);
  localparam int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int TMR_W    = $clog2(DEBOUNCE_CYCLES);
  localparam int SETTLE_W = $clog2(SYNC_STAGES + 1);

  logic [NUM_COLS-1:0] colSync;
  logic [ROW_W-1:0]    rowIdx;
  logic [COL_W-1:0]    colIdx;
  logic [SETTLE_W-1:0] settleCnt;
  logic [TMR_W-1:0]    timer;
  logic [3:0]          keyIdx;
  logic                lastCol;
  logic                lastRow;

  kpad_colsync #(.WIDTH(NUM_COLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (colIn),
    .dOut (colSync)
  );

  assign lastCol = (colIdx == COL_W'(NUM_COLS - 1));
  assign lastRow = (rowIdx == ROW_W'(NUM_ROWS - 1));

  // position walker: columns inside a row, then the next row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowIdx    <= '0;
      colIdx    <= '0;
      settleCnt <= SETTLE_W'(SYNC_STAGES);
    end else if (strb.advance) begin
      if (lastCol) begin
        colIdx    <= '0;
        rowIdx    <= lastRow ? '0 : rowIdx + 1'b1;
        settleCnt <= SETTLE_W'(SYNC_STAGES);
      end else begin
        colIdx <= colIdx + 1'b1;
      end
    end else if (strb.settle && settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

  // debounce interval timer, shared by press recheck and release wait
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timer <= '0;
    else if (strb.timerClr) timer <= '0;
    else if (strb.timerRun) timer <= timer + 1'b1;
  end

  assign keyIdx = 4'(rowIdx) * 4'(NUM_COLS) + 4'(colIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyCode  <= 8'h00;
      keyValid <= 1'b0;
    end else begin
      keyValid <= strb.latchCode;
      if (strb.latchCode) keyCode <= hexAscii(keyIdx);
    end
  end

  always_comb begin
    rowDrive         = '1;
    rowDrive[rowIdx] = 1'b0;
  end

  assign stat.settled   = (settleCnt == '0);
  assign stat.keyLow    = ~colSync[colIdx];
  assign stat.allHigh   = &colSync;
  assign stat.timerDone = (timer == TMR_W'(DEBOUNCE_CYCLES - 1));
endmodule

// File: rtl/kpad_ctrl.sv
module kpad_ctrl
  import kpad_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  kpStatus_t stat,
  output kpStrobe_t strb
);
  scanState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SCAN;
    else       state <= nxt;
  end

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      ST_SCAN: begin
        if (!stat.settled) begin
          strb.settle = 1'b1;
        end else if (stat.keyLow) begin
          strb.timerClr = 1'b1;
          nxt           = ST_WAIT;
        end else begin
          strb.advance = 1'b1;
        end
      end
      ST_WAIT: begin
        if (stat.timerDone) nxt = ST_CHECK;
        else                strb.timerRun = 1'b1;
      end
      ST_CHECK: begin
        if (stat.keyLow) begin
          strb.latchCode = 1'b1;
          strb.timerClr  = 1'b1;
          nxt            = ST_RELEASE;
        end else begin
          strb.advance = 1'b1;
          nxt          = ST_SCAN;
        end
      end
      ST_RELEASE: begin
        if (!stat.allHigh) begin
          strb.timerClr = 1'b1;
        end else if (stat.timerDone) begin
          strb.advance = 1'b1;
          nxt          = ST_SCAN;
        end else begin
          strb.timerRun = 1'b1;
        end
      end
      default: nxt = ST_SCAN;
    endcase
  end
endmodule

// File: rtl/kpad_scanner.sv
module kpad_scanner
  import kpad_pkg::*;
#(
  parameter int NUM_ROWS        = 4,
  parameter int NUM_COLS        = 4,
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 1_250_000  // 10 ms at 125 MHz
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_COLS-1:0] colIn,
  output logic [NUM_ROWS-1:0] rowDrive,
  output logic [7:0]          keyCode,
  output logic                keyValid
);
  kpStrobe_t strb;
  kpStatus_t stat;

  kpad_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .strb (strb)
  );

  kpad_datapath #(
    .NUM_ROWS        (NUM_ROWS),
    .NUM_COLS        (NUM_COLS),
    .SYNC_STAGES     (SYNC_STAGES),
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .colIn    (colIn),
    .strb     (strb),
    .stat     (stat),
    .rowDrive (rowDrive),
    .keyCode  (keyCode),
    .keyValid (keyValid)
  );
endmodule

// File: rtl/kpad_scanner_chk.sv
module kpad_scanner_chk #(
  parameter int NUM_ROWS        = 4,
  parameter int NUM_COLS        = 4,
  parameter int DEBOUNCE_CYCLES = 1_250_000
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_COLS-1:0] colIn,
  input logic [NUM_ROWS-1:0] rowDrive,
  input logic [7:0]          keyCode,
  input logic                keyValid
);
  localparam int RUN_W = $clog2(DEBOUNCE_CYCLES + 1);

  logic [NUM_ROWS-1:0] prevRow;
  logic [RUN_W-1:0]    runCnt;
  logic                relSeen;
  logic                allHigh;

  assign allHigh = &colIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRow <= {{(NUM_ROWS-1){1'b1}}, 1'b0};
      runCnt  <= '0;
      relSeen <= 1'b1;
    end else begin
      prevRow <= rowDrive;
      if (!allHigh)                                       runCnt <= '0;
      else if (runCnt != RUN_W'(DEBOUNCE_CYCLES))         runCnt <= runCnt + 1'b1;
      if (keyValid)                                       relSeen <= 1'b0;
      else if (allHigh && runCnt >= RUN_W'(DEBOUNCE_CYCLES - 1)) relSeen <= 1'b1;
    end
  end

  AST_ONE_ROW_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~rowDrive) == 1);  // R2

  AST_ROW_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    (rowDrive != prevRow) |-> (rowDrive == {prevRow[NUM_ROWS-2:0], prevRow[NUM_ROWS-1]}));  // R3

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> !keyValid);  // R7

  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !keyValid |=> (!keyValid || 1'b1) && ($stable(keyCode) || keyValid));  // R7

  AST_CODE_HEX: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |-> ((keyCode >= 8'h30 && keyCode <= 8'h39) || (keyCode >= 8'h41 && keyCode <= 8'h46)));  // R4

  AST_RELEASE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |-> relSeen);  // R9
endmodule

bind kpad_scanner kpad_scanner_chk #(
  .NUM_ROWS        (NUM_ROWS),
  .NUM_COLS        (NUM_COLS),
  .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .colIn    (colIn),
  .rowDrive (rowDrive),
  .keyCode  (keyCode),
  .keyValid (keyValid)
);

// File: tb/kpad_scanner_tb.sv
`timescale 1ns/1ps
module kpad_scanner_tb;
  localparam int DB   = 40;
  localparam int SYNC = 2;
  localparam int SCAN = 4 * (SYNC + 4);

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] colIn;
  logic [3:0] rowDrive;
  logic [7:0] keyCode;
  logic       keyValid;

  bit keyOn = 1'b0;
  int keyRow = 0;
  int keyCol = 0;
  int nCheck = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  // switch matrix model: closed key pulls its column low while its row is driven low
  always_comb begin
    colIn = 4'hF;
    if (keyOn && rowDrive[keyRow] == 1'b0) colIn[keyCol] = 1'b0;
  end

  kpad_scanner #(.SYNC_STAGES(SYNC), .DEBOUNCE_CYCLES(DB)) u_dut (
    .clk(clk), .rstN(rstN), .colIn(colIn),
    .rowDrive(rowDrive), .keyCode(keyCode), .keyValid(keyValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int expCode(input int r, input int c);
    int k = 4 * r + c;
    return (k < 10) ? (48 + k) : (65 + k - 10);
  endfunction

  task automatic countPulses(input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (keyValid) k++;
    end
  endtask

  // press from idle, wait for the report, check code, latency and pulse width
  task automatic pressExpect(input int r, input int c, input string req);
    int lat = 0;
    keyRow = r; keyCol = c; keyOn = 1'b1;
    while (lat < DB + SCAN + 40) begin
      @(negedge clk);
      lat++;
      if (keyValid) break;
    end
    check(keyValid, req, int'(keyValid), 1);
    check(keyCode == 8'(expCode(r, c)), "R4", keyCode, expCode(r, c));
    check(lat >= DB && lat <= DB + SCAN + 8, "R5", lat, DB);
    @(negedge clk);
    check(!keyValid, "R7", int'(keyValid), 0);
  endtask

  initial begin
    int k;
    logic [3:0] prev;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rowDrive == 4'b1110, "R1", rowDrive, 4'b1110);
    check(!keyValid, "R1", int'(keyValid), 0);
    check(keyCode == 8'h00, "R1", keyCode, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rowDrive == 4'b1110, "R1", rowDrive, 4'b1110);

    // R2 / R3 idle row sequence
    prev = rowDrive;
    k = 0;
    for (int i = 0; i < 4 * SCAN; i++) begin
      @(negedge clk);
      check($countones(~rowDrive) == 1, "R2", rowDrive, 0);
      if (rowDrive != prev) begin
        check(rowDrive == {prev[2:0], prev[3]}, "R3", rowDrive, {prev[2:0], prev[3]});
        k++;
      end
      prev = rowDrive;
    end
    check(k >= 12, "R3", k, 12);

    // exhaustive key sweep: R4, R5, R7, R8
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        pressExpect(r, c, "R4");
        countPulses(2 * DB, k);
        check(k == 0, "R8", k, 0);
        check(keyCode == 8'(expCode(r, c)), "R7", keyCode, expCode(r, c));
        keyOn = 1'b0;
        countPulses(2 * DB + SCAN, k);
        check(k == 0, "R8", k, 0);
      end
    end

    // R6 short presses released before the recheck
    for (int i = 0; i < 3; i++) begin
      held = keyCode;
      keyRow = i + 1; keyCol = 3 - i; keyOn = 1'b1;
      repeat (SCAN + 4) @(negedge clk);
      keyOn = 1'b0;
      countPulses(2 * DB + SCAN, k);
      check(k == 0, "R6", k, 0);
      check(keyCode == held, "R6", keyCode, held);
    end

    // R8 bounce burst then steady hold gives one report
    keyRow = 2; keyCol = 1;
    for (int i = 0; i < 5; i++) begin
      keyOn = 1'b1; repeat (3) @(negedge clk);
      keyOn = 1'b0; repeat (3) @(negedge clk);
    end
    keyOn = 1'b1;
    countPulses(3 * DB + SCAN + 8, k);
    check(k == 1, "R8", k, 1);
    check(keyCode == 8'(expCode(2, 1)), "R8", keyCode, expCode(2, 1));

    // R9 short release does not re-arm
    keyOn = 1'b0;
    repeat (DB / 2) @(negedge clk);
    keyOn = 1'b1;
    countPulses(3 * DB, k);
    check(k == 0, "R9", k, 0);
    keyOn = 1'b0;
    countPulses(2 * DB + SCAN, k);
    check(k == 0, "R9", k, 0);
    // full release lets the same key report again
    pressExpect(2, 1, "R9");
    keyOn = 1'b0;
    countPulses(2 * DB + SCAN, k);
    check(k == 0, "R9", k, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nCheck++;
      nFail++;
      $display("FAIL watchdog (R1-run): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
      $finish;
    end
  end
endmodule